// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-programmed master for clause-22 management frames on a two-wire PHY management bus. Software loads a divider value, then writes one 32-bit command word that already carries every field of the frame: start pattern, opcode, PHY address, register address, turnaround and 16 data bits. That write launches the frame with no separate start bit. The controller first sends 32 preamble ones, then shifts the command word out MSB first on MDIO while generating MDC.

For a read (opcode `10`), the controller releases MDIO from the second turnaround bit onward. It samples the PHY's 16 reply bits on MDC rising edges and shifts them into the low half of the same command/data register. A completion flag at bit 23 of the event register marks the end of every frame. Software clears that flag by writing a one to it. MDIO changes only while MDC is low, and MDC idles low between frames.

The register map has three entries. Address 0 holds the command/data word. Address 1 is the event register. Address 2 holds the divider S, where MDC = clk / (2·S) and S = 0 behaves as S = 1. Address 3 reads as zero.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low, and registers 0, 1 and 2 all read as zero.
- R2: A write to address 0 while idle starts a 64-bit frame. The frame is 32 ones followed by bits 31 down to 0 of the written word, one bit per MDC period. A frame starts only after such a write.
- R3: The MDC period is 2·S system clocks, where S is the value in address 2 (S = 0 gives a period of 2 clocks).
- R4: The MDIO output and its enable never change while MDC is high. They change only on the clock where MDC falls, or when a frame starts.
- R5: If bits 29:28 of the command are `10` (read), the output enable is low for frame bits 47 to 63 (the second turnaround bit to the end). For any other opcode the enable is high for all 64 bits.
- R6: After a read, bits 15:0 of address 0 hold the 16 values sampled on MDC rising edges during frame bits 48 to 63, with the first sample in bit 15. Bits 31:16 keep the command.
- R7: At the end of every frame, bit 23 of address 1 becomes one.
- R8: Writing address 1 with bit 23 set clears the flag. Writing it with bit 23 clear leaves the flag set.
- R9: A write to address 0 during a frame is ignored: the frame in progress and the register contents are unchanged.
- R10: Once a frame ends, MDC returns low and the MDIO output enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command/data, 1 event, 2 divider) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Every PHY address.** A write frame is sent to each of the 32 PHY addresses. A field slipped by one bit position would corrupt the frame pattern compared bit by bit.
- **Divider sweep including zero.** Reads and writes run with divider values 0, 1, 2, 3 and 5. An off-by-one in the half-period count shows up as a wrong MDC period. A zero divider that is not clamped stalls the clock, so the completion flag never appears.
- **Bus release point.** The enable is checked bit by bit. A controller that releases MDIO one bit early or late, or turns the bus around on write frames, is caught.
- **Reply alignment.** Distinct reply words expose reversed or shifted reply bits.
- **Command write during a frame.** Writing the command register mid-frame would restart or corrupt the frame in flight.
- **Write-one-to-clear.** Writing zero to the event flag is checked to leave it set. A controller that clears on any write fails this case.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_PAYLOAD
    } mdio_state_e;

    localparam int CMD_W      = 32;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + CMD_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA2_IDX    = PRE_BITS + 15;
    localparam int HDR_LAST   = TA2_IDX;
    localparam int REPLY_W    = 16;
    localparam int EVT_BIT    = 23;

    localparam int ADDR_DATA  = 0;
    localparam int ADDR_EVT   = 1;
    localparam int ADDR_SPD   = 2;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             tick;

    always_comb begin
        lim    = (half_i == '0) ? DIV_W'(1) : half_i;
        tick   = run_i && (cnt_q >= lim - DIV_W'(1));
        rise_o = tick && !mdc_o;
        fall_o = tick && mdc_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (!run_i) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_o <= ~mdc_o;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_fsm.sv
`timescale 1ns/1ps
module mdio_fsm
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             busy_o,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done_o,
    output logic             cap_o
);
    mdio_state_e      st_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pos;
    logic             cmd_bit;

    // state register and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q  <= ST_PREAMBLE;
                        idx_q <= '0;
                    end
                end
                ST_PREAMBLE: begin
                    if (fall_i) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(PRE_BITS - 1)) st_q <= ST_HEADER;
                    end
                end
                ST_HEADER: begin
                    if (fall_i) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(HDR_LAST)) st_q <= ST_PAYLOAD;
                    end
                end
                ST_PAYLOAD: begin
                    if (fall_i) begin
                        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                            st_q  <= ST_IDLE;
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pos     = IDX_W'(FRAME_BITS - 1) - idx_q;
        cmd_bit = cmd_i[pos[$clog2(CMD_W)-1:0]];
        busy_o  = (st_q != ST_IDLE);
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        done_o  = 1'b0;
        cap_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HEADER: begin
                mdio_oe = !(rd_i && idx_q == IDX_W'(TA2_IDX));
                mdio_o  = mdio_oe && cmd_bit;
            end
            ST_PAYLOAD: begin
                mdio_oe = !rd_i;
                mdio_o  = mdio_oe && cmd_bit;
                cap_o   = rd_i && rise_i;
                done_o  = fall_i && (idx_q == IDX_W'(FRAME_BITS - 1));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [CMD_W-1:0] data_q;
    logic             evt_q;
    logic [DIV_W-1:0] spd_q;
    logic             busy, start, done, cap, rise, fall, is_rd;
    logic             wr_data, wr_evt, wr_spd;

    always_comb begin
        wr_data = reg_wr && (reg_addr == ADDR_W'(ADDR_DATA));
        wr_evt  = reg_wr && (reg_addr == ADDR_W'(ADDR_EVT));
        wr_spd  = reg_wr && (reg_addr == ADDR_W'(ADDR_SPD));
        start   = wr_data && !busy;
        is_rd   = (data_q[29:28] == OP_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            evt_q  <= 1'b0;
            spd_q  <= '0;
        end else begin
            if (start)
                data_q <= reg_wdata;
            else if (cap)
                data_q[REPLY_W-1:0] <= {data_q[REPLY_W-2:0], mdio_i};
            if (done)
                evt_q <= 1'b1;
            else if (wr_evt && reg_wdata[EVT_BIT])
                evt_q <= 1'b0;
            if (wr_spd)
                spd_q <= reg_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(ADDR_DATA): reg_rdata = data_q;
            ADDR_W'(ADDR_EVT):  reg_rdata[EVT_BIT] = evt_q;
            ADDR_W'(ADDR_SPD):  reg_rdata[DIV_W-1:0] = spd_q;
            default:            reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .half_i (spd_q),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .rd_i    (is_rd),
        .rise_i  (rise),
        .fall_i  (fall),
        .cmd_i   (data_q),
        .busy_o  (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done_o  (done),
        .cap_o   (cap)
    );
endmodule

// File: rtl/mdio_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_ctrl_chk
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              evt
);
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt);

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == ADDR_W'(ADDR_DATA)));
endmodule

bind mdio_ctrl mdio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .evt      (evt_q)
);

// File: tb/tb_mdio_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int          total = 0;
    int          bad = 0;
    int          nbit = 0;
    logic [63:0] obit = '0;
    logic [63:0] oebit = '0;
    realtime     t_r1 = 0, t_r2 = 0;
    logic [15:0] reply = '0;

    always #2 clk = ~clk;

    mdio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY-side observer: record each bit on the MDC rising edge
    always @(posedge mdc) begin
        #1;
        if (nbit < 64) begin
            obit[nbit]  = mdio_o;
            oebit[nbit] = mdio_oe;
        end
        if (nbit == 1) t_r1 = $realtime;
        if (nbit == 2) t_r2 = $realtime;
        nbit = nbit + 1;
    end

    // PHY-side driver: TA zero, then reply MSB first, else pull-up
    always @* begin
        if (nbit == 47)                  mdio_i = 1'b0;
        else if (nbit >= 48 && nbit < 64) mdio_i = reply[63 - nbit];
        else                             mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 2'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 2'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output logic seen);
        logic [31:0] v;
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            rd(1, v);
            seen = v[23];
        end
    endtask

    function automatic logic [63:0] exp_bits(input logic [31:0] cmd);
        logic [63:0] e;
        for (int k = 0; k < 64; k++) e[k] = (k < 32) ? 1'b1 : cmd[63 - k];
        return e;
    endfunction

    function automatic logic [63:0] exp_oe(input logic [31:0] cmd);
        logic [63:0] e;
        for (int k = 0; k < 64; k++) e[k] = !(cmd[29:28] == 2'b10 && k >= 47);
        return e;
    endfunction

    task automatic frame(input logic [31:0] cmd, input logic [15:0] rep, input int s);
        logic        seen;
        logic [31:0] v;
        logic [63:0] eoe;
        bit          isr;
        isr   = (cmd[29:28] == 2'b10);
        reply = rep;
        wr(2, 32'(s));
        nbit  = 0;
        wr(0, cmd);
        wait_done(seen);
        chk("R7 event flag", {63'd0, seen}, 64'd1);
        eoe = exp_oe(cmd);
        chk("R2 frame bits", obit & eoe, exp_bits(cmd) & eoe);
        chk("R5 output enable", oebit, eoe);
        chk("R2 bit count", 64'(nbit), 64'd64);
        chk("R3 mdc period", 64'(int'((t_r2 - t_r1) / 4.0)), 64'(2 * ((s == 0) ? 1 : s)));
        chk("R10 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
        rd(0, v);
        if (isr) chk("R6 reply", 64'(v), 64'({cmd[31:16], rep}));
        else     chk("R2 data kept", 64'(v), 64'(cmd));
        wr(1, 32'h0080_0000);
        rd(1, v);
        chk("R8 flag cleared", 64'(v), 64'd0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic        seen;
        logic [31:0] ca, cb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 3; a++) begin
            rd(a, v);
            chk("R1 register reset", 64'(v), 64'd0);
        end
        chk("R1 pins reset", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2/R5: write frames to every PHY address
        for (int p = 0; p < 32; p++)
            frame({2'b01, 2'b01, 5'(p), 5'(p ^ 7), 2'b10, 16'(p * 16'h0931)}, 16'h0, 1);

        // R3/R6: divider sweep, reads and writes
        for (int i = 0; i < 5; i++) begin
            int s;
            s = (i == 4) ? 5 : i;
            frame({2'b01, 2'b10, 5'(s + 3), 5'(s * 2), 2'b10, 16'h0}, 16'hA5C3 ^ 16'(s * 16'h1111), s);
            frame({2'b01, 2'b01, 5'(s + 9), 5'(s + 1), 2'b10, 16'hF00F ^ 16'(s)}, 16'h0, s);
        end

        // R6: reads over several addresses
        for (int p = 0; p < 8; p++)
            frame({2'b01, 2'b10, 5'(p * 4), 5'(31 - p), 2'b10, 16'hFFFF}, 16'(p * 16'h1357 + 1), 1);

        // R9: command write during a frame is ignored
        ca = {2'b01, 2'b01, 5'd17, 5'd4, 2'b10, 16'h1234};
        cb = {2'b01, 2'b10, 5'd2, 5'd9, 2'b10, 16'h0000};
        wr(2, 32'd2);
        nbit = 0;
        wr(0, ca);
        repeat (20) @(negedge clk);
        wr(0, cb);
        rd(0, v);
        chk("R9 register unchanged", 64'(v), 64'(ca));
        wait_done(seen);
        chk("R9 frame completes", {63'd0, seen}, 64'd1);
        chk("R9 frame unaltered", obit, exp_bits(ca));
        chk("R9 enable unaltered", oebit, exp_oe(ca));

        // R8: writing zero leaves the flag set
        wr(1, 32'h0000_0000);
        rd(1, v);
        chk("R8 zero write keeps flag", 64'(v), 64'h0080_0000);
        wr(1, 32'hFF7F_FFFF);
        rd(1, v);
        chk("R8 other bits keep flag", 64'(v), 64'h0080_0000);
        wr(1, 32'h0080_0000);
        rd(1, v);
        chk("R8 one write clears", 64'(v), 64'd0);

        finish_run();
    end
endmodule